// File: doc/BRIEF.md
# Effective Address Generation Unit

This block resolves the operand of one instruction for a 32-bit CISC core with eight address registers and eight data registers. From the addressing mode, the operand size, a register number and up to two 16-bit extension words, it produces one of two things. For a memory operand it gives the effective address. For a register-direct or immediate operand it gives the operand value itself. It also reports how many extension words the mode used.

For the post-increment and pre-decrement modes it also returns the new value of the selected address register, together with a write-enable pulse. The register file sits outside the block and applies the write.

The inputs are captured when `req_valid` is high. The results come out of one register stage, on the following cycle, with `res_valid` marking them. Between requests the result fields keep their last values. The write-enable is a single-cycle pulse that goes with `res_valid`.

Top module: `ea_unit`

Mode codes on `mode`:
- 0: data register direct
- 1: address register direct
- 2: register indirect
- 3: post-increment
- 4: pre-decrement
- 5: displacement
- 6: indexed
- 7: absolute short
- 8: absolute long
- 9: PC displacement
- 10: PC indexed
- 11: immediate
- 12 to 15: undefined

Size codes on `size`:
- 0: byte
- 1: word
- 2: long

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `res_valid`, `an_wr_en`, `ea`, `an_wr_val`, `opnd_val` and `ext_used` are all zero.
- R2: `res_valid` is high in exactly the cycle after a cycle with `req_valid` high. In cycles without a request, `ea`, `an_wr_idx`, `an_wr_val`, `opnd_val` and `ext_used` keep their previous values.
- R3: For register indirect (mode 2), `ea` equals the selected address register and `ext_used` is 0.
- R4: For post-increment (mode 3), `ea` is the register value before the update, and `an_wr_val` is that value plus the step. The step is 1, 2 or 4 for byte, word or long, except that a byte access through register 7 steps by 2.
- R5: For pre-decrement (mode 4), the register value minus the same step as in R4 is both `ea` and `an_wr_val`.
- R6: For displacement (mode 5), `ea` is the address register plus `ext0` sign-extended from 16 bits, and `ext_used` is 1.
- R7: For indexed (mode 6), `ea` is the address register, plus `ext0[7:0]` sign-extended, plus an index value, and `ext_used` is 1. The index register is chosen by the fields of `ext0`:
  - `ext0[15]` selects the file: 0 for data registers, 1 for address registers.
  - `ext0[14:12]` gives the register number.
  - `ext0[11]` selects the index width: 0 takes the low 16 bits sign-extended, 1 takes all 32 bits.
- R8: For absolute short (mode 7), `ea` is `ext0` sign-extended, with `ext_used` 1. For absolute long (mode 8), `ea` is `{ext0, ext1}`, with `ext_used` 2.
- R9: Modes 9 and 10 compute R6 and R7 respectively, but with `ext_pc` (the address of the first extension word) in place of the address register.
- R10: For immediate (mode 11), `opnd_val` is one of the following, and `ea` is 0:
  - byte: `ext0[7:0]` zero-extended, with `ext_used` 1;
  - word: `ext0` zero-extended, with `ext_used` 1;
  - long: `{ext0, ext1}`, with `ext_used` 2.
- R11: For register direct (modes 0 and 1), `opnd_val` is the selected data or address register, masked to the operand size and zero-extended. `ea` is 0 and `ext_used` is 0. In every memory mode, `opnd_val` is 0.
- R12: Mode codes 12 to 15 give `ea`, `opnd_val` and `ext_used` of zero, and no register write.
- R13: `an_wr_en` pulses together with `res_valid` only for modes 3 and 4, and `an_wr_idx` then equals the requested register number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Capture the request inputs this cycle |
| mode | input | 4 | Addressing mode code |
| size | input | 2 | Operand size code |
| reg_sel | input | 3 | Register number from the opcode |
| ext0 | input | 16 | First extension word |
| ext1 | input | 16 | Second extension word |
| ext_pc | input | 32 | Address of the first extension word |
| areg_flat | input | 256 | Address registers, register n in bits 32n+31:32n |
| dreg_flat | input | 256 | Data registers, same packing |
| res_valid | output | 1 | Results are new this cycle |
| ea | output | 32 | Effective address |
| an_wr_en | output | 1 | Address register write pulse |
| an_wr_idx | output | 3 | Address register to write |
| an_wr_val | output | 32 | New address register value |
| opnd_val | output | 32 | Immediate or register-direct operand |
| ext_used | output | 2 | Extension words consumed |

## Verification
The assertions assume that `size` never carries the unused code 3, and that `req_valid` stays low while reset is applied. Under those assumptions, the result stage always follows a known request. The stimulus draws sizes only from 0 to 2, and it holds `req_valid` low until after reset is released. Mode codes, including the undefined ones, are drawn over their whole range. Register contents and extension words are free, which lets the address sums wrap.

// File: rtl/ea_pkg.sv
// Shared widths, mode codes and size codes for the effective address unit.
// Assumes the data width is exactly two extension words wide.
package ea_pkg;
    localparam int EA_DW   = 32;
    localparam int EA_EW   = 16;
    localparam int EA_NREG = 8;
    localparam int EA_RW   = $clog2(EA_NREG);

    typedef enum logic [3:0] {
        M_DDIR    = 4'd0,
        M_ADIR    = 4'd1,
        M_IND     = 4'd2,
        M_POSTINC = 4'd3,
        M_PREDEC  = 4'd4,
        M_DISP    = 4'd5,
        M_INDEX   = 4'd6,
        M_ABSW    = 4'd7,
        M_ABSL    = 4'd8,
        M_PCDISP  = 4'd9,
        M_PCINDEX = 4'd10,
        M_IMM     = 4'd11
    } ea_mode_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
    localparam logic [1:0] SZ_LONG = 2'd2;
endpackage

// File: rtl/ea_step.sv
// Post-increment / pre-decrement adjuster.
// Picks the step from the operand size, forcing a step of 2 for byte
// accesses through the stack register so it stays word aligned.
// Assumes size code 3 is never presented (it is treated as long).
module ea_step #(
    parameter int DW     = 32,
    parameter int RW     = 3,
    parameter int SP_IDX = 7
) (
    input  logic [DW-1:0] base,
    input  logic [1:0]    size,
    input  logic [RW-1:0] reg_sel,
    input  logic          dec,
    output logic [DW-1:0] new_val
);
    import ea_pkg::*;

    logic [2:0] step;

    // Step amount in bytes for the current access.
    always_comb begin
        case (size)
            SZ_BYTE: step = (reg_sel == RW'(SP_IDX)) ? 3'd2 : 3'd1;
            SZ_WORD: step = 3'd2;
            default: step = 3'd4;
        endcase
    end

    // Apply the step in the requested direction.
    always_comb begin
        if (dec) new_val = base - DW'(step);
        else     new_val = base + DW'(step);
    end
endmodule

// File: rtl/ea_index.sv
// Brief-format index offset: sign-extended 8-bit displacement plus an
// index register chosen and sized by fields of the extension word.
// Assumes bit 15 = file select, bits 14:12 = register, bit 11 = long index.
module ea_index #(
    parameter int DW   = 32,
    parameter int EW   = 16,
    parameter int NREG = 8
) (
    input  logic [EW-1:0]            ext,
    input  logic [NREG-1:0][DW-1:0]  areg,
    input  logic [NREG-1:0][DW-1:0]  dreg,
    output logic [DW-1:0]            offset
);
    localparam int RW      = $clog2(NREG);
    localparam int SEL_BIT = EW - 1;
    localparam int NUM_LO  = EW - 1 - RW;
    localparam int LONG_BIT = NUM_LO - 1;
    localparam int DISP_W  = 8;

    logic [RW-1:0] xnum;
    logic [DW-1:0] xraw;
    logic [DW-1:0] xval;
    logic [DW-1:0] disp;

    // Pick the index register from the chosen file.
    always_comb begin
        xnum = ext[SEL_BIT-1:NUM_LO];
        xraw = ext[SEL_BIT] ? areg[xnum] : dreg[xnum];
    end

    // Size the index and sign-extend the short displacement.
    always_comb begin
        xval   = ext[LONG_BIT] ? xraw : {{(DW-EW){xraw[EW-1]}}, xraw[EW-1:0]};
        disp   = {{(DW-DISP_W){ext[DISP_W-1]}}, ext[DISP_W-1:0]};
        offset = disp + xval;
    end
endmodule

// File: rtl/ea_operand.sv
// Operand value for non-memory modes: register direct (masked to size)
// and immediate data taken from the extension words.
// Assumes the data width equals two extension words.
module ea_operand #(
    parameter int DW   = 32,
    parameter int EW   = 16,
    parameter int NREG = 8
) (
    input  logic [3:0]               mode,
    input  logic [1:0]               size,
    input  logic [$clog2(NREG)-1:0]  reg_sel,
    input  logic [EW-1:0]            ext0,
    input  logic [EW-1:0]            ext1,
    input  logic [NREG-1:0][DW-1:0]  areg,
    input  logic [NREG-1:0][DW-1:0]  dreg,
    output logic [DW-1:0]            value
);
    import ea_pkg::*;

    localparam int BW = 8;

    logic [DW-1:0] src;

    // Raw source value before size masking.
    always_comb begin
        case (ea_mode_e'(mode))
            M_DDIR:  src = dreg[reg_sel];
            M_ADIR:  src = areg[reg_sel];
            M_IMM:   src = {ext0, ext1};
            default: src = '0;
        endcase
    end

    // Size selection; immediates sit in the low byte or word of ext0.
    always_comb begin
        value = '0;
        if (ea_mode_e'(mode) == M_IMM) begin
            case (size)
                SZ_BYTE: value = {{(DW-BW){1'b0}}, ext0[BW-1:0]};
                SZ_WORD: value = {{(DW-EW){1'b0}}, ext0};
                default: value = src;
            endcase
        end else begin
            case (size)
                SZ_BYTE: value = {{(DW-BW){1'b0}}, src[BW-1:0]};
                SZ_WORD: value = {{(DW-EW){1'b0}}, src[EW-1:0]};
                default: value = src;
            endcase
        end
    end
endmodule

// File: rtl/ea_unit.sv
// Effective address unit top. Unpacks the register files, combines the
// step, index and operand helpers per mode, and registers the results
// one cycle after req_valid. The address register write is a one-cycle pulse.
// Assumes req_valid is low during reset and size never equals 3.
module ea_unit #(
    parameter int DW     = ea_pkg::EA_DW,
    parameter int EW     = ea_pkg::EA_EW,
    parameter int NREG   = ea_pkg::EA_NREG,
    parameter int SP_IDX = NREG - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [3:0]              mode,
    input  logic [1:0]              size,
    input  logic [2:0]              reg_sel,
    input  logic [15:0]             ext0,
    input  logic [15:0]             ext1,
    input  logic [31:0]             ext_pc,
    input  logic [255:0]            areg_flat,
    input  logic [255:0]            dreg_flat,
    output logic                    res_valid,
    output logic [31:0]             ea,
    output logic                    an_wr_en,
    output logic [2:0]              an_wr_idx,
    output logic [31:0]             an_wr_val,
    output logic [31:0]             opnd_val,
    output logic [1:0]              ext_used
);
    import ea_pkg::*;

    localparam int RW = $clog2(NREG);

    logic [NREG-1:0][DW-1:0] areg;
    logic [NREG-1:0][DW-1:0] dreg;

    // Unpack one register of each file per generate iteration.
    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign areg[g] = areg_flat[g*DW +: DW];
        assign dreg[g] = dreg_flat[g*DW +: DW];
    end

    logic [DW-1:0] an_cur;
    logic [DW-1:0] an_next;
    logic [DW-1:0] idx_off;
    logic [DW-1:0] opnd_c;
    logic [DW-1:0] disp16;
    logic [DW-1:0] ea_c;
    logic [DW-1:0] wv_c;
    logic          we_c;
    logic [1:0]    ext_c;
    logic          is_dec;

    assign an_cur = areg[reg_sel];
    assign disp16 = {{(DW-EW){ext0[EW-1]}}, ext0};
    assign is_dec = (ea_mode_e'(mode) == M_PREDEC);

    ea_step #(.DW(DW), .RW(RW), .SP_IDX(SP_IDX)) u_step (
        .base    (an_cur),
        .size    (size),
        .reg_sel (reg_sel),
        .dec     (is_dec),
        .new_val (an_next)
    );

    ea_index #(.DW(DW), .EW(EW), .NREG(NREG)) u_index (
        .ext    (ext0),
        .areg   (areg),
        .dreg   (dreg),
        .offset (idx_off)
    );

    ea_operand #(.DW(DW), .EW(EW), .NREG(NREG)) u_opnd (
        .mode    (mode),
        .size    (size),
        .reg_sel (reg_sel),
        .ext0    (ext0),
        .ext1    (ext1),
        .areg    (areg),
        .dreg    (dreg),
        .value   (opnd_c)
    );

    // Per-mode address, write-back and extension word count.
    always_comb begin
        ea_c  = '0;
        wv_c  = '0;
        we_c  = 1'b0;
        ext_c = 2'd0;
        case (ea_mode_e'(mode))
            M_IND:     ea_c = an_cur;
            M_POSTINC: begin ea_c = an_cur;  wv_c = an_next; we_c = 1'b1; end
            M_PREDEC:  begin ea_c = an_next; wv_c = an_next; we_c = 1'b1; end
            M_DISP:    begin ea_c = an_cur + disp16;  ext_c = 2'd1; end
            M_INDEX:   begin ea_c = an_cur + idx_off; ext_c = 2'd1; end
            M_ABSW:    begin ea_c = disp16;           ext_c = 2'd1; end
            M_ABSL:    begin ea_c = {ext0, ext1};     ext_c = 2'd2; end
            M_PCDISP:  begin ea_c = ext_pc + disp16;  ext_c = 2'd1; end
            M_PCINDEX: begin ea_c = ext_pc + idx_off; ext_c = 2'd1; end
            M_IMM:     ext_c = (size == SZ_BYTE || size == SZ_WORD) ? 2'd1 : 2'd2;
            default:   ;
        endcase
    end

    // Result stage: load on request, write pulse lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            an_wr_en  <= 1'b0;
            ea        <= '0;
            an_wr_idx <= '0;
            an_wr_val <= '0;
            opnd_val  <= '0;
            ext_used  <= '0;
        end else begin
            res_valid <= req_valid;
            an_wr_en  <= req_valid && we_c;
            if (req_valid) begin
                ea        <= ea_c;
                an_wr_idx <= reg_sel;
                an_wr_val <= wv_c;
                opnd_val  <= opnd_c;
                ext_used  <= ext_c;
            end
        end
    end
endmodule

// File: rtl/ea_unit_chk.sv
// Property checker for ea_unit, attached by bind. Observes ports only.
// Assumes req_valid is low while reset is asserted.
module ea_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  mode,
    input logic        res_valid,
    input logic [31:0] ea,
    input logic        an_wr_en,
    input logic [31:0] an_wr_val,
    input logic [31:0] opnd_val,
    input logic [1:0]  ext_used
);
    AST_WE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        an_wr_en |-> res_valid); // R13
    AST_WE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        an_wr_en |-> ($past(mode) == 4'd3 || $past(mode) == 4'd4)); // R13
    AST_POST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(mode) == 4'd3) |->
            (an_wr_en && ((an_wr_val - ea) == 32'd1 || (an_wr_val - ea) == 32'd2
                          || (an_wr_val - ea) == 32'd4))); // R4
    AST_PRE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(mode) == 4'd4) |-> (an_wr_en && ea == an_wr_val)); // R5
    AST_ABSL_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(mode) == 4'd8) |-> ext_used == 2'd2); // R8
    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(mode) >= 4'd12) |->
            (ea == 32'd0 && opnd_val == 32'd0 && ext_used == 2'd0)); // R12
endmodule

bind ea_unit ea_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .res_valid (res_valid),
    .ea        (ea),
    .an_wr_en  (an_wr_en),
    .an_wr_val (an_wr_val),
    .opnd_val  (opnd_val),
    .ext_used  (ext_used)
);

// File: tb/tb_ea_unit.sv
module tb_ea_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  mode = '0;
    logic [1:0]  size = '0;
    logic [2:0]  reg_sel = '0;
    logic [15:0] ext0 = '0, ext1 = '0;
    logic [31:0] ext_pc = '0;
    logic [255:0] areg_flat, dreg_flat;
    logic        res_valid, an_wr_en;
    logic [31:0] ea, an_wr_val, opnd_val;
    logic [2:0]  an_wr_idx;
    logic [1:0]  ext_used;

    logic [31:0] A [8];
    logic [31:0] D [8];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    logic        x_valid = 0, x_we = 0;
    logic [31:0] x_ea = 0, x_wv = 0, x_op = 0;
    logic [2:0]  x_idx = 0;
    logic [1:0]  x_ext = 0;
    logic [3:0]  x_mode = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .size(size),
        .reg_sel(reg_sel), .ext0(ext0), .ext1(ext1), .ext_pc(ext_pc),
        .areg_flat(areg_flat), .dreg_flat(dreg_flat), .res_valid(res_valid),
        .ea(ea), .an_wr_en(an_wr_en), .an_wr_idx(an_wr_idx), .an_wr_val(an_wr_val),
        .opnd_val(opnd_val), .ext_used(ext_used)
    );

    always_comb begin
        for (int i = 0; i < 8; i++) begin
            areg_flat[i*32 +: 32] = A[i];
            dreg_flat[i*32 +: 32] = D[i];
        end
    end

    function automatic string tag_of(input logic [3:0] m);
        case (m)
            0, 1:  return "R11";
            2:     return "R3";
            3:     return "R4";
            4:     return "R5";
            5:     return "R6";
            6:     return "R7";
            7, 8:  return "R8";
            9, 10: return "R9";
            11:    return "R10";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [31:0] sx16(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    // index term of the brief extension word, written from R7
    function automatic logic [31:0] index_term(input logic [15:0] e);
        logic [31:0] r;
        int n = int'(e[14:12]);
        r = e[15] ? A[n] : D[n];
        if (!e[11]) r = sx16(r[15:0]);
        return r + {{24{e[7]}}, e[7:0]};
    endfunction

    // behavioural reference, updated at each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            x_valid = 0; x_we = 0; x_ea = 0; x_wv = 0; x_op = 0; x_idx = 0; x_ext = 0;
        end else begin
            x_valid = req_valid;
            x_we = 0;
            if (req_valid) begin
                int stp;
                logic [31:0] an;
                an = A[reg_sel];
                stp = (size == 0) ? ((reg_sel == 7) ? 2 : 1) : (size == 1 ? 2 : 4);
                x_mode = mode; x_idx = reg_sel;
                x_ea = 0; x_wv = 0; x_op = 0; x_ext = 0;
                case (mode)
                    0: x_op = (size == 0) ? (D[reg_sel] & 32'hFF) : (size == 1 ? (D[reg_sel] & 32'hFFFF) : D[reg_sel]);
                    1: x_op = (size == 0) ? (an & 32'hFF) : (size == 1 ? (an & 32'hFFFF) : an);
                    2: x_ea = an;
                    3: begin x_ea = an; x_wv = an + stp; x_we = 1; end
                    4: begin x_ea = an - stp; x_wv = an - stp; x_we = 1; end
                    5: begin x_ea = an + sx16(ext0); x_ext = 1; end
                    6: begin x_ea = an + index_term(ext0); x_ext = 1; end
                    7: begin x_ea = sx16(ext0); x_ext = 1; end
                    8: begin x_ea = {ext0, ext1}; x_ext = 2; end
                    9: begin x_ea = ext_pc + sx16(ext0); x_ext = 1; end
                    10: begin x_ea = ext_pc + index_term(ext0); x_ext = 1; end
                    11: begin
                        x_op = (size == 0) ? {24'd0, ext0[7:0]} : (size == 1 ? {16'd0, ext0} : {ext0, ext1});
                        x_ext = (size == 2) ? 2 : 1;
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string t, input string f, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", t, f, act, exp);
        end
    endtask

    task automatic compare_all();
        string t = tag_of(x_mode);
        chk("R2", "res_valid", 32'(res_valid), 32'(x_valid));
        chk("R13", "an_wr_en", 32'(an_wr_en), 32'(x_we));
        chk(t, "ea", ea, x_ea);
        chk(t, "an_wr_val", an_wr_val, x_wv);
        chk("R13", "an_wr_idx", 32'(an_wr_idx), 32'(x_idx));
        chk(t, "opnd_val", opnd_val, x_op);
        chk(t, "ext_used", 32'(ext_used), 32'(x_ext));
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic issue(input logic [3:0] m, input logic [1:0] s, input logic [2:0] r,
                         input logic [15:0] e0, input logic [15:0] e1, input logic [31:0] pc);
        req_valid = 1; mode = m; size = s; reg_sel = r; ext0 = e0; ext1 = e1; ext_pc = pc;
        tick();
        req_valid = 0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            A[i] = 32'h1000_0000 + 32'(i) * 32'h0001_0010;
            D[i] = 32'hFFFF_8000 + 32'(i) * 32'h0000_1111;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "res_valid", 32'(res_valid), 0);
        chk("R1", "an_wr_en", 32'(an_wr_en), 0);
        chk("R1", "ea", ea, 0);
        chk("R1", "opnd_val", opnd_val, 0);
        rst_n = 1;
        tick();
        chk("R1", "ext_used", 32'(ext_used), 0);
        chk("R1", "an_wr_val", an_wr_val, 0);

        issue(2, 2, 3, 16'h0, 16'h0, 0);            // R3
        issue(3, 0, 7, 0, 0, 0);                    // R4 stack byte steps 2
        issue(3, 0, 6, 0, 0, 0);                    // R4 byte steps 1
        issue(3, 1, 2, 0, 0, 0);                    // R4 word
        issue(3, 2, 1, 0, 0, 0);                    // R4 long
        issue(4, 0, 7, 0, 0, 0);                    // R5 stack byte
        issue(4, 0, 0, 0, 0, 0);                    // R5 byte
        issue(4, 2, 5, 0, 0, 0);                    // R5 long
        tick(); tick();                             // R2 hold while idle
        issue(5, 1, 4, 16'h8000, 0, 0);             // R6 negative disp
        issue(5, 1, 4, 16'h7FFF, 0, 0);             // R6 positive disp
        issue(6, 1, 1, 16'h3080, 0, 0);             // R7 data, short index, disp -128
        issue(6, 1, 1, 16'hB87F, 0, 0);             // R7 addr, long index, disp 127
        issue(7, 1, 0, 16'hFFFE, 0, 0);             // R8 short negative
        issue(8, 1, 0, 16'h1234, 16'h5678, 0);      // R8 long
        issue(9, 1, 0, 16'hFFF0, 0, 32'h0000_4002); // R9 pc disp
        issue(10, 1, 0, 16'hF8FC, 0, 32'h0000_4002);// R9 pc index
        issue(11, 0, 0, 16'hABCD, 16'h1111, 0);     // R10 byte
        issue(11, 1, 0, 16'hABCD, 16'h1111, 0);     // R10 word
        issue(11, 2, 0, 16'hABCD, 16'h1111, 0);     // R10 long
        issue(0, 0, 3, 0, 0, 0);                    // R11 data byte
        issue(1, 1, 5, 0, 0, 0);                    // R11 addr word
        issue(0, 2, 7, 0, 0, 0);                    // R11 data long
        issue(12, 2, 3, 16'hFFFF, 16'hFFFF, 32'hFFFF_FFFF); // R12
        issue(15, 0, 7, 16'hFFFF, 16'hFFFF, 32'hFFFF_FFFF); // R12
        for (int k = 0; k < 600; k++) begin
            if (k % 50 == 0) begin
                for (int i = 0; i < 8; i++) begin A[i] = $urandom; D[i] = $urandom; end
            end
            if ($urandom % 4 == 0) tick();
            else issue(4'($urandom % 16), 2'($urandom % 3), 3'($urandom),
                       16'($urandom), 16'($urandom), $urandom);
        end
        tick(); tick();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule